// File: doc/BRIEF.md
# Interrupt Entry Sequencer for a Three-Stage Pipeline

This block decides when an instruction pipeline with fetch, decode and execute stages takes an interrupt, and it does so without a branch. Each cycle it owns one fetch slot. Usually that slot reads the next sequential program address. After a request wins arbitration, two control cycles pass, which still fetch normally. The block then places the two words of the winner's vector slot into the stream. If neither word is a one-word subroutine jump, sequential fetching resumes from where it stopped.

If a vector word turns out to be a one-word subroutine jump, the service becomes a long routine. The sequencer saves the program counter and the status register on a small internal stack, moves the program counter to the jump target and raises the interrupt mask. A return-from-interrupt pulse restores both saved values.

Entry is also gated in two other ways. A hardware repeat that suspends fetching holds back every entry until it ends. A spacing rule keeps consecutive first vector fetches apart by a minimum count of fetched words.

Top module: `irq_seq_ctl`

## Requirements
- R1: Reset clears the status register and the stack-error flag, leaves every acknowledge low and presents RESET_PC as the fetch address with fetch_en high.
- R2: With nothing pending and no hold, each cycle fetches program address pc with fetch_vec low, and pc advances by one per fetch.
- R3: A request sampled high at a clock edge is accepted in the next cycle (A). Cycles A, A+1 and A+2 fetch sequentially. A+3 and A+4 fetch vec_base+2*i and vec_base+2*i+1 with fetch_vec high. A+5 resumes at the next sequential address.
- R4: irq_ack[i] is a one-cycle pulse in the cycle of the first vector fetch of source i, and source i's pending latch clears at the same time, so one request gives one service.
- R5: Each source's level is irq_lvl[2*i+1:2*i]. Among eligible pending sources the highest level wins, and equal levels go to the lowest index.
- R6: A source is eligible when its level is greater than the mask sr_out[1:0], when its level is 3, or when its bit is set in BYPASS (default sources 0 to 2).
- R7: When a vector fetch has fetch_is_jsr high, the next fetch is fetch_target. The current pc and status register are pushed, and the mask becomes the larger of the old mask and the serviced level. A jump in the first word cancels the second vector fetch.
- R8: A pulse on rti_exec with a non-empty stack loads pc and the status register from the top entry, so the following fetch uses the saved address.
- R9: A push onto a full stack (DEPTH entries) is dropped, and a pop from an empty stack leaves pc and the status register unchanged. Both set stk_err, which stays high until reset.
- R10: Between two first vector fetches there are at least SPACING other fetched words. After a long entry through the first vector word, the next acceptance is delayed accordingly.
- R11: While rep_hold is high, fetch_en is low, pc and the sequence state stay frozen and nothing is accepted. A request that arrives during the hold is taken in the first cycle after it, and three sequential fetches still precede its vector words.
- R12: A pending request that is masked stays latched and is serviced once a return lowers the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Per-source request, latched while high |
| irq_lvl | input | 2*NSRC | Two-bit priority level per source |
| vec_base | input | AW | Base address of the vector table |
| rep_hold | input | 1 | Fetch suspended by an active repeat |
| rti_exec | input | 1 | Return-from-interrupt executed this cycle |
| fetch_is_jsr | input | 1 | Word at fetch_addr is a one-word subroutine jump |
| fetch_target | input | AW | Target of that jump |
| fetch_en | output | 1 | A word is fetched this cycle |
| fetch_addr | output | AW | Fetch address |
| fetch_vec | output | 1 | The fetch comes from a vector slot |
| irq_ack | output | NSRC | One-hot acknowledge on the first vector fetch |
| sr_out | output | SRW | Status register, mask in bits 1:0 |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The scoreboard follows the fetch slot cycle by cycle through several request patterns. A single request shows the three-fetch delay and the two-word insertion. Three requests arriving together, two of them at the same level, separate level order from index order. A request arriving while the mask is raised must wait for the return, which tells a dropped request from a latched one. A second, higher request queued behind a long entry shows the spacing delay, since without that rule it would be accepted one cycle earlier. A request arriving during a repeat hold shows that the hold freezes both the fetch slot and acceptance. Nested non-maskable entries on a two-deep stack, followed by returns, show which frame survives an overflow.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   localparam int LVL_W = 2;
   localparam logic [LVL_W-1:0] LVL_TOP = 2'd3;

   typedef enum logic [2:0] {
      ST_RUN,
      ST_CTL1,
      ST_CTL2,
      ST_VEC0,
      ST_VEC1
   } seq_state_e;

   function automatic logic [LVL_W-1:0] lvl_max(input logic [LVL_W-1:0] a,
                                                 input logic [LVL_W-1:0] b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
   parameter int NSRC = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req,
   input  logic [NSRC-1:0] clr,
   output logic [NSRC-1:0] pend
);
   for (genvar g = 0; g < NSRC; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pend[g] <= 1'b0;
         else        pend[g] <= (pend[g] & ~clr[g]) | req[g];
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_seq_pkg::*;
#(
   parameter int              NSRC   = 8,
   parameter logic [NSRC-1:0] BYPASS = '0,
   localparam int             IDX_W  = $clog2(NSRC)
) (
   input  logic [NSRC-1:0]       pend,
   input  logic [LVL_W*NSRC-1:0] lvl,
   input  logic [LVL_W-1:0]      mask,
   output logic                  any,
   output logic [IDX_W-1:0]      idx,
   output logic [LVL_W-1:0]      lvl_sel
);
   logic [NSRC-1:0] elig;

   for (genvar g = 0; g < NSRC; g++) begin : g_elig
      if (BYPASS[g]) begin : g_free
         assign elig[g] = pend[g];
      end else begin : g_masked
         assign elig[g] = pend[g] &&
                          ((lvl[LVL_W*g +: LVL_W] > mask) ||
                           (lvl[LVL_W*g +: LVL_W] == LVL_TOP));
      end
   end

   always_comb begin
      any     = 1'b0;
      idx     = '0;
      lvl_sel = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (elig[i] && (!any || lvl[LVL_W*i +: LVL_W] >= lvl_sel)) begin
            any     = 1'b1;
            idx     = IDX_W'(i);
            lvl_sel = lvl[LVL_W*i +: LVL_W];
         end
      end
   end
endmodule

// File: rtl/irq_frame_stack.sv
module irq_frame_stack #(
   parameter int W     = 24,
   parameter int DEPTH = 8,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic         pop,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout,
   output logic         empty,
   output logic         err
);
   logic [W-1:0]  slot [DEPTH];
   logic [CW-1:0] cnt;
   logic          full;

   assign full  = (cnt == CW'(DEPTH));
   assign empty = (cnt == '0);
   assign dout  = slot[PW'(cnt - CW'(1))];

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (push && cnt == CW'(g)) slot[g] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         err <= 1'b0;
      end else begin
         if (push && !full)       cnt <= cnt + CW'(1);
         else if (pop && !empty)  cnt <= cnt - CW'(1);
         if ((push && full) || (pop && empty)) err <= 1'b1;
      end
   end
endmodule

// File: rtl/irq_seq_ctl.sv
module irq_seq_ctl
   import irq_seq_pkg::*;
#(
   parameter int              NSRC     = 8,
   parameter int              AW       = 16,
   parameter int              SRW      = 8,
   parameter int              DEPTH    = 8,
   parameter int              SPACING  = 4,
   parameter logic [NSRC-1:0] BYPASS   = 8'h07,
   parameter logic [AW-1:0]   RESET_PC = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NSRC-1:0]       irq_req,
   input  logic [LVL_W*NSRC-1:0] irq_lvl,
   input  logic [AW-1:0]         vec_base,
   input  logic                  rep_hold,
   input  logic                  rti_exec,
   input  logic                  fetch_is_jsr,
   input  logic [AW-1:0]         fetch_target,
   output logic                  fetch_en,
   output logic [AW-1:0]         fetch_addr,
   output logic                  fetch_vec,
   output logic [NSRC-1:0]       irq_ack,
   output logic [SRW-1:0]        sr_out,
   output logic                  stk_err
);
   localparam int IDX_W = $clog2(NSRC);
   localparam int GW    = $clog2(SPACING + 1);
   localparam int FW    = AW + SRW;

   if (NSRC < 2)              begin : g_chk_nsrc  $error("NSRC must be at least 2"); end
   if (SRW < LVL_W)           begin : g_chk_srw   $error("SRW must hold the mask bits"); end
   if (DEPTH < 1)             begin : g_chk_depth $error("DEPTH must be at least 1"); end
   if (SPACING < 1)           begin : g_chk_space $error("SPACING must be at least 1"); end
   if (AW < IDX_W + 2)        begin : g_chk_aw    $error("AW too narrow for vector slots"); end

   seq_state_e        state;
   logic [AW-1:0]     pc;
   logic [SRW-1:0]    sr;
   logic [IDX_W-1:0]  cur_idx;
   logic [LVL_W-1:0]  cur_lvl;
   logic [GW-1:0]     gap_cnt;

   logic [NSRC-1:0]   pend;
   logic              pick_any;
   logic [IDX_W-1:0]  pick_idx;
   logic [LVL_W-1:0]  pick_lvl;

   logic              adv, in_vec, gap_ok, accept, long_go, rti_go, pop_ok;
   logic              stk_empty;
   logic [FW-1:0]     frame_top;
   logic [AW-1:0]     vec_addr;

   irq_pend #(.NSRC(NSRC)) u_pend (
      .clk (clk),
      .rst_n (rst_n),
      .req (irq_req),
      .clr (irq_ack),
      .pend (pend)
   );

   irq_pick #(.NSRC(NSRC), .BYPASS(BYPASS)) u_pick (
      .pend (pend),
      .lvl (irq_lvl),
      .mask (sr[LVL_W-1:0]),
      .any (pick_any),
      .idx (pick_idx),
      .lvl_sel (pick_lvl)
   );

   irq_frame_stack #(.W(FW), .DEPTH(DEPTH)) u_stack (
      .clk (clk),
      .rst_n (rst_n),
      .push (long_go),
      .pop (rti_go),
      .din ({pc, sr}),
      .dout (frame_top),
      .empty (stk_empty),
      .err (stk_err)
   );

   assign adv     = !rep_hold;
   assign in_vec  = (state == ST_VEC0) || (state == ST_VEC1);
   assign gap_ok  = (32'(gap_cnt) + 3) >= SPACING;
   assign accept  = (state == ST_RUN) && adv && pick_any && gap_ok;
   assign long_go = adv && in_vec && fetch_is_jsr;
   assign rti_go  = rti_exec && !long_go;
   assign pop_ok  = rti_go && !stk_empty;

   assign vec_addr   = vec_base + AW'({cur_idx, 1'b0}) + AW'(state == ST_VEC1);
   assign fetch_en   = adv;
   assign fetch_vec  = adv && in_vec;
   assign fetch_addr = in_vec ? vec_addr : pc;
   assign sr_out     = sr;

   always_comb begin
      irq_ack = '0;
      if (adv && state == ST_VEC0) irq_ack[cur_idx] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_RUN;
         cur_idx <= '0;
         cur_lvl <= '0;
      end else if (adv) begin
         unique case (state)
            ST_RUN: if (accept) begin
               state   <= ST_CTL1;
               cur_idx <= pick_idx;
               cur_lvl <= pick_lvl;
            end
            ST_CTL1: state <= ST_CTL2;
            ST_CTL2: state <= ST_VEC0;
            ST_VEC0: state <= fetch_is_jsr ? ST_RUN : ST_VEC1;
            ST_VEC1: state <= ST_RUN;
            default: state <= ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc <= RESET_PC;
         sr <= '0;
      end else if (long_go) begin
         pc               <= fetch_target;
         sr[LVL_W-1:0]    <= lvl_max(sr[LVL_W-1:0], cur_lvl);
      end else if (pop_ok) begin
         pc <= frame_top[FW-1:SRW];
         sr <= frame_top[SRW-1:0];
      end else if (adv && !in_vec) begin
         pc <= pc + AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_cnt <= GW'(SPACING);
      end else if (adv) begin
         if (state == ST_VEC0)              gap_cnt <= '0;
         else if (32'(gap_cnt) < SPACING)   gap_cnt <= gap_cnt + GW'(1);
      end
   end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
   parameter int NSRC    = 8,
   parameter int AW      = 16,
   parameter int SRW     = 8,
   parameter int SPACING = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            rep_hold,
   input logic            fetch_en,
   input logic            fetch_vec,
   input logic [AW-1:0]   fetch_addr,
   input logic            fetch_is_jsr,
   input logic [AW-1:0]   fetch_target,
   input logic [NSRC-1:0] irq_ack,
   input logic [SRW-1:0]  sr_out
);
   logic [15:0] since_ack;
   logic        seen_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_ack <= '0;
         seen_ack  <= 1'b0;
      end else if (fetch_en) begin
         if (|irq_ack) begin
            since_ack <= '0;
            seen_ack  <= 1'b1;
         end else if (since_ack != 16'hFFFF) begin
            since_ack <= since_ack + 16'd1;
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n && fetch_en && (|irq_ack) && seen_ack)
         assert_vec_spacing_R10: assert (since_ack >= 16'(SPACING))
            else $error("first vector fetches too close: %0d", since_ack);
   end

   assert_ack_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq_ack));

   assert_ack_on_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (|irq_ack) |-> fetch_vec);

   assert_hold_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rep_hold |-> (irq_ack == '0 && !fetch_vec));

   assert_second_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((|irq_ack) && !fetch_is_jsr) |=> (rep_hold || fetch_vec));

   assert_long_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vec && fetch_is_jsr) |=>
         (rep_hold || (!fetch_vec && fetch_addr == $past(fetch_target))));

   assert_mask_rises_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vec && fetch_is_jsr) |=> (sr_out[1:0] >= $past(sr_out[1:0])));
endmodule

bind irq_seq_ctl irq_seq_chk #(
   .NSRC(NSRC), .AW(AW), .SRW(SRW), .SPACING(SPACING)
) u_irq_seq_chk (.*);

// File: tb/test_irq_seq_ctl.sv
module test_irq_seq_ctl;
   localparam int NSRC = 8;
   localparam int AW = 16;
   localparam int SRW = 8;
   localparam int DEPTH = 2;
   localparam int SPACING = 4;
   localparam logic [AW-1:0] BASE = 16'h0100;
   localparam logic [AW-1:0] RPC = 16'h0040;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n;
   logic [NSRC-1:0] irq_req;
   logic [2*NSRC-1:0] irq_lvl;
   logic [AW-1:0] vec_base;
   logic rep_hold, rti_exec, fetch_is_jsr;
   logic [AW-1:0] fetch_target;
   logic fetch_en, fetch_vec, stk_err;
   logic [AW-1:0] fetch_addr;
   logic [NSRC-1:0] irq_ack;
   logic [SRW-1:0] sr_out;

   irq_seq_ctl #(.NSRC(NSRC), .AW(AW), .SRW(SRW), .DEPTH(DEPTH),
                 .SPACING(SPACING), .BYPASS(8'h07), .RESET_PC(RPC)) i_irq_seq_ctl (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_lvl(irq_lvl),
      .vec_base(vec_base), .rep_hold(rep_hold), .rti_exec(rti_exec),
      .fetch_is_jsr(fetch_is_jsr), .fetch_target(fetch_target),
      .fetch_en(fetch_en), .fetch_addr(fetch_addr), .fetch_vec(fetch_vec),
      .irq_ack(irq_ack), .sr_out(sr_out), .stk_err(stk_err));

   // memory model: first word of a vector slot is a jump for sources in jsr_src
   logic [NSRC-1:0] jsr_src;
   logic [AW-1:0] off;
   always_comb begin
      off = fetch_addr - BASE;
      fetch_is_jsr = fetch_vec && jsr_src[off[3:1]] && !off[0];
      fetch_target = 16'h0800 + AW'(off[3:1]) * 16'h0040;
   end

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   typedef struct {
      logic en;
      logic [AW-1:0] addr;
      logic vec;
      logic [NSRC-1:0] ack;
      string tag;
   } exp_t;
   exp_t q[$];
   exp_t e;

   always @(negedge clk) begin
      if (q.size() > 0) begin
         e = q.pop_front();
         checks++;
         if (fetch_en !== e.en || irq_ack !== e.ack ||
             (e.en && (fetch_addr !== e.addr || fetch_vec !== e.vec))) begin
            failures++;
            $display("FAIL %s actual en=%b addr=%h vec=%b ack=%h expected en=%b addr=%h vec=%b ack=%h",
                     e.tag, fetch_en, fetch_addr, fetch_vec, irq_ack,
                     e.en, e.addr, e.vec, e.ack);
         end
      end
   end

   logic [AW-1:0] pc_m;
   logic [AW-1:0] saved_q[$];

   task automatic cyc(input logic en, input logic [AW-1:0] a, input logic v,
                      input int ack_i, input string tag);
      exp_t x;
      x.en = en; x.addr = a; x.vec = v; x.tag = tag;
      x.ack = '0;
      if (ack_i >= 0) x.ack[ack_i] = 1'b1;
      q.push_back(x);
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic norm(input string tag);
      cyc(1'b1, pc_m, 1'b0, -1, tag);
      pc_m = pc_m + 1;
   endtask

   task automatic pulse(input logic [NSRC-1:0] m, input string tag);
      irq_req = m;
      norm(tag);
      irq_req = '0;
   endtask

   task automatic short_svc(input int i, input string tag);
      norm(tag); norm(tag); norm(tag);
      cyc(1'b1, BASE + AW'(2*i), 1'b1, i, tag);
      cyc(1'b1, BASE + AW'(2*i + 1), 1'b1, -1, tag);
   endtask

   task automatic long_svc(input int i, input string tag);
      norm(tag); norm(tag); norm(tag);
      saved_q.push_back(pc_m);
      cyc(1'b1, BASE + AW'(2*i), 1'b1, i, tag);
      pc_m = 16'h0800 + AW'(i) * 16'h0040;
   endtask

   task automatic rti(input string tag);
      rti_exec = 1'b1;
      norm(tag);
      rti_exec = 1'b0;
      pc_m = saved_q.pop_back();
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
      pc_m = RPC;
      saved_q.delete();
   endtask

   initial begin
      #400000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      irq_req = '0; rep_hold = 1'b0; rti_exec = 1'b0; jsr_src = '0;
      vec_base = BASE;
      irq_lvl = 16'hB940; // levels 7:2 6:3 5:2 4:1 3:1 others 0
      do_reset();

      // R1 reset state
      chk("R1 fetch_addr", 32'(fetch_addr), 32'(RPC));
      chk("R1 sr", 32'(sr_out), 0);
      chk("R1 stk_err", 32'(stk_err), 0);
      chk("R1 ack", 32'(irq_ack), 0);
      chk("R1 fetch_en", 32'(fetch_en), 1);

      // R2 sequential fetch
      repeat (3) norm("R2 sequential");

      // R3 R4 single request
      pulse(8'h20, "R3 request");
      short_svc(5, "R3 R4 single service");
      norm("R4 no second service");
      norm("R4 no second service");

      // R5 priority: 5 (lvl2) then 3 and 4 (lvl1, tie to lowest index)
      pulse(8'h38, "R5 request");
      short_svc(5, "R5 highest level");
      short_svc(3, "R5 tie lowest index");
      short_svc(4, "R5 remaining");
      norm("R5 drained");

      // R7 long entry, R6 masking, R8 return, R12 latched request
      jsr_src = 8'h08;
      pulse(8'h08, "R7 request");
      long_svc(3, "R7 long entry");
      chk("R7 mask raised", 32'(sr_out[1:0]), 1);
      pulse(8'h10, "R6 masked request");
      repeat (5) norm("R6 masked level not taken");
      pulse(8'h20, "R6 higher level");
      short_svc(5, "R6 higher level taken");
      rti("R8 return");
      chk("R8 mask restored", 32'(sr_out), 0);
      short_svc(4, "R12 latched request served after return");
      norm("R8 resume");

      // R10 spacing after a long entry through the first vector word
      pulse(8'h08, "R10 request");
      norm("R10"); irq_req = 8'h40; norm("R10"); irq_req = '0; norm("R10");
      saved_q.push_back(pc_m);
      cyc(1'b1, BASE + 16'd6, 1'b1, 3, "R10 long entry");
      pc_m = 16'h0800 + 16'h00C0;
      norm("R10 spacing delays acceptance");
      short_svc(6, "R10 delayed service");
      rti("R8 return after spacing");
      norm("R10 resume");

      // R11 repeat hold
      rep_hold = 1'b1;
      cyc(1'b0, '0, 1'b0, -1, "R11 hold");
      irq_req = 8'h20;
      cyc(1'b0, '0, 1'b0, -1, "R11 hold with request");
      irq_req = '0;
      cyc(1'b0, '0, 1'b0, -1, "R11 hold");
      cyc(1'b0, '0, 1'b0, -1, "R11 hold");
      rep_hold = 1'b0;
      short_svc(5, "R11 entry after hold");
      norm("R11 resume");

      // R9 overflow, R6 bypass
      jsr_src = 8'h40;
      pulse(8'h40, "R9 first entry");
      long_svc(6, "R9 first entry");
      chk("R6 mask top", 32'(sr_out[1:0]), 3);
      pulse(8'h40, "R6 level 3 unmaskable");
      long_svc(6, "R9 second entry");
      chk("R9 no error yet", 32'(stk_err), 0);
      pulse(8'h40, "R9 third entry");
      long_svc(6, "R9 third entry");
      void'(saved_q.pop_back());
      chk("R9 overflow flag", 32'(stk_err), 1);
      pulse(8'h02, "R6 bypass source");
      short_svc(1, "R6 bypass source under mask 3");
      rti("R9 pop second frame");
      chk("R9 mask of second frame", 32'(sr_out[1:0]), 3);
      rti("R9 pop first frame");
      chk("R9 mask of first frame", 32'(sr_out), 0);
      norm("R9 resume");

      // R9 underflow
      do_reset();
      chk("R1 reset clears error", 32'(stk_err), 0);
      rti_exec = 1'b1;
      norm("R9 pop empty");
      rti_exec = 1'b0;
      norm("R9 pc unchanged by empty pop");
      chk("R9 underflow flag", 32'(stk_err), 1);
      chk("R9 sr unchanged", 32'(sr_out), 0);

      @(posedge clk); #1;
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule